// File: doc/BRIEF.md
# Paged Indirect Register Access Sequencer

This block sits between a host that wants to read or write a register inside a paged switch register space and a management-bus master that can only move 16-bit words to and from a small set of management registers at one PHY address. Each host request names a page, a register offset inside that page, an access width (8, 16, 32, 48 or 64 bits), a direction and, for writes, the value. The block turns it into a short, ordered series of management transactions.

The page is selected only when it differs from the page last written, which saves one transaction on every access that stays in the same page. Wide values are spread across consecutive 16-bit data registers with the least significant word first. After the operation command is issued, the self-clearing command register is polled a bounded number of times, with a programmable idle gap between polls. A read then collects the data words. The result comes back with a one-cycle done strobe and an error flag. The error flag is set when polling runs out or when any management transaction fails.

Top module: `pg_seq`

## Requirements
- R1: The page register (management register 0x10) is written with the page number in bits 15:8 and bit 0 set. This write happens only when the requested page differs from the cached page. The cache resets to 0xFF and is updated only by a page write that completes without error.
- R2: For a write, the needed data words go first to registers 0x18, 0x19, 0x1A and 0x1B in ascending order, least significant word first. Then the command register 0x11 is written with the offset in bits 15:8 and bit 0 set.
- R3: For a read, the command register 0x11 is written with the offset in bits 15:8 and bit 1 set. After completion the data words are read in ascending order from 0x18 and assembled with 0x18 as the least significant word. An 8-bit read returns only the low byte of 0x18, and all other result bits are zero.
- R4: Completion is detected when a read of 0x11 returns bits 1:0 both clear. The first poll follows the command at once. While busy, the next poll starts after pollGap idle cycles with no request asserted.
- R5: At most POLL_LIMIT polls are made. If all of them read busy, the access ends with the error flag, no data register is read, and the read result is zero.
- R6: A management transaction that completes with mgmtErr ends the access at once with the error flag and a zero read result, and no further transaction is issued. A failed page write leaves the page cache unchanged.
- R7: Every transaction targets PHY address PHY_ADDR. The register number and write data stay constant while mgmtReq is high until mgmtDone.
- R8: ready is high only when no access is in progress. reqValid is ignored while ready is low. done is high for exactly one cycle, and rData holds its value until the next accepted request. Reset state: ready high, done low, mgmtReq low.
- R9: Width codes are 0 for 8 bits, 1 for 16, 2 for 32, 3 for 48 and 4 for 64, using 1, 1, 2, 3 and 4 data words. Codes 5 to 7 behave as 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request strobe, taken while ready is high |
| reqPage | input | 8 | Requested page |
| reqReg | input | 8 | Register offset inside the page |
| reqWidth | input | 3 | Access width code |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWData | input | 64 | Write value, right-aligned |
| pollGap | input | 8 | Idle cycles between busy polls |
| ready | output | 1 | Sequencer idle, request may be given |
| done | output | 1 | One-cycle completion strobe |
| error | output | 1 | Access failed, valid with done |
| rData | output | 64 | Read result, right-aligned |
| mgmtReq | output | 1 | Management transaction request |
| mgmtWrite | output | 1 | Transaction direction, 1 for write |
| mgmtPhy | output | 5 | Target PHY address |
| mgmtRegNum | output | 5 | Target management register |
| mgmtWData | output | 16 | Transaction write word |
| mgmtRData | input | 16 | Transaction read word, valid with mgmtDone |
| mgmtDone | input | 1 | Transaction completed |
| mgmtErr | input | 1 | Transaction failed, valid with mgmtDone |

## Verification
A stale page cache shows up at the ports within one access: either a page write that should have been skipped, or a missing page write. A bad word index or width decode shows as a wrong register number in the transaction log, or as a misplaced word in rData, as soon as the first multi-word access completes. A fault in the poll counter or the gap counter shows as the wrong number of polls before done, or as wrong spacing between poll starts. A fault in abort handling shows as transactions issued after a failed one, or as non-zero data returned with the error flag.

// File: rtl/pg_seq_pkg.sv
package pg_seq_pkg;
  localparam logic [4:0] REG_PAGE   = 5'h10;
  localparam logic [4:0] REG_CMD    = 5'h11;
  localparam logic [4:0] REG_DATA0  = 5'h18;
  localparam logic [7:0] PAGE_RESET = 8'hFF;

  typedef enum logic [2:0] {
    TX_NONE, TX_PAGE, TX_DWR, TX_CMD, TX_POLL, TX_DRD
  } txKind_t;

  typedef struct packed {
    txKind_t kind;
    logic    latchReq;
    logic    pageWritten;
    logic    clearIdx;
    logic    incIdx;
    logic    captureWord;
    logic    dropData;
  } seqCtl_t;
endpackage

// File: rtl/pg_seq_dp.sv
module pg_seq_dp
  import pg_seq_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd30,
  parameter int DATA_W = 64,
  parameter int WORD_W = 16,
  parameter int NWORDS = DATA_W / WORD_W,
  parameter int IDX_W  = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [7:0]        reqPage,
  input  logic [7:0]        reqReg,
  input  logic [2:0]        reqWidth,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [WORD_W-1:0] mgmtRData,
  output logic              pageHit,
  output logic              lastWord,
  output logic              latWrite,
  output logic [4:0]        mgmtPhy,
  output logic [4:0]        mgmtRegNum,
  output logic [WORD_W-1:0] mgmtWData,
  output logic [DATA_W-1:0] rData
);
  logic [7:0]        pageQ, regQ, pageCache;
  logic [2:0]        widthQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [IDX_W-1:0]  idx, lastIdx;
  logic [WORD_W-1:0] captWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ <= '0; regQ <= '0; widthQ <= '0; writeQ <= 1'b0; wdataQ <= '0;
      pageCache <= PAGE_RESET; idx <= '0;
    end else begin
      if (ctl.latchReq) begin
        pageQ <= reqPage; regQ <= reqReg; widthQ <= reqWidth;
        writeQ <= reqWrite; wdataQ <= reqWData;
      end
      if (ctl.pageWritten) pageCache <= pageQ;
      if (ctl.latchReq || ctl.clearIdx) idx <= '0;
      else if (ctl.incIdx) idx <= idx + 1'b1;
    end
  end

  always_comb begin
    unique case (widthQ)
      3'd0, 3'd1: lastIdx = IDX_W'(0);
      3'd2:       lastIdx = IDX_W'(1);
      3'd3:       lastIdx = IDX_W'(2);
      default:    lastIdx = IDX_W'(NWORDS - 1);
    endcase
  end

  assign pageHit  = (reqPage == pageCache);
  assign lastWord = (idx == lastIdx);
  assign latWrite = writeQ;
  assign mgmtPhy  = PHY_ADDR;
  assign captWord = (widthQ == 3'd0) ? {{(WORD_W-8){1'b0}}, mgmtRData[7:0]} : mgmtRData;

  always_comb begin
    mgmtRegNum = '0;
    mgmtWData  = '0;
    unique case (ctl.kind)
      TX_PAGE: begin
        mgmtRegNum = REG_PAGE;
        mgmtWData  = {pageQ, 7'b0, 1'b1};
      end
      TX_DWR: begin
        mgmtRegNum = REG_DATA0 + 5'(idx);
        mgmtWData  = wdataQ[idx*WORD_W +: WORD_W];
      end
      TX_CMD: begin
        mgmtRegNum = REG_CMD;
        mgmtWData  = {regQ, 6'b0, ~writeQ, writeQ};
      end
      TX_POLL: mgmtRegNum = REG_CMD;
      TX_DRD:  mgmtRegNum = REG_DATA0 + 5'(idx);
      default: ;
    endcase
  end

  for (genvar g = 0; g < NWORDS; g++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN || ctl.latchReq || ctl.dropData)
        rData[g*WORD_W +: WORD_W] <= '0;
      else if (ctl.captureWord && idx == IDX_W'(g))
        rData[g*WORD_W +: WORD_W] <= captWord;
    end
  end

  // a page write is only issued for a page that differs from the cache
  assert_page_skip_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.kind == TX_PAGE) |-> (pageQ != pageCache));
endmodule

// File: rtl/pg_seq_ctrl.sv
module pg_seq_ctrl
  import pg_seq_pkg::*;
#(
  parameter int POLL_LIMIT = 5,
  parameter int GAP_W      = 8,
  parameter int CNT_W      = $clog2(POLL_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             pageHit,
  input  logic             lastWord,
  input  logic             latWrite,
  input  logic             mgmtDone,
  input  logic             mgmtErr,
  input  logic [1:0]       busyBits,
  input  logic [GAP_W-1:0] pollGap,
  output seqCtl_t          ctl,
  output logic             mgmtReq,
  output logic             mgmtWrite,
  output logic             ready,
  output logic             done,
  output logic             error
);
  typedef enum logic [2:0] {
    S_IDLE, S_PAGE, S_DWR, S_CMD, S_POLL, S_GAP, S_DRD, S_FIN
  } state_t;

  state_t           state, nextState;
  logic [CNT_W-1:0] pollCnt;
  logic [GAP_W-1:0] gapCnt;
  logic             errQ, setErr, pollClr, pollInc, gapLoad;

  always_comb begin
    ctl = '0;
    nextState = state;
    setErr = 1'b0; pollClr = 1'b0; pollInc = 1'b0; gapLoad = 1'b0;
    unique case (state)
      S_PAGE: ctl.kind = TX_PAGE;
      S_DWR:  ctl.kind = TX_DWR;
      S_CMD:  ctl.kind = TX_CMD;
      S_POLL: ctl.kind = TX_POLL;
      S_DRD:  ctl.kind = TX_DRD;
      default: ctl.kind = TX_NONE;
    endcase
    unique case (state)
      S_IDLE: if (reqValid) begin
        ctl.latchReq = 1'b1;
        nextState = !pageHit ? S_PAGE : (reqWrite ? S_DWR : S_CMD);
      end
      S_PAGE: if (mgmtDone) begin
        if (mgmtErr) setErr = 1'b1;
        else begin
          ctl.pageWritten = 1'b1;
          nextState = latWrite ? S_DWR : S_CMD;
        end
      end
      S_DWR: if (mgmtDone) begin
        if (mgmtErr) setErr = 1'b1;
        else if (lastWord) nextState = S_CMD;
        else ctl.incIdx = 1'b1;
      end
      S_CMD: if (mgmtDone) begin
        if (mgmtErr) setErr = 1'b1;
        else begin
          pollClr = 1'b1;
          nextState = S_POLL;
        end
      end
      S_POLL: if (mgmtDone) begin
        if (mgmtErr) setErr = 1'b1;
        else if (busyBits == 2'b00) begin
          if (latWrite) nextState = S_FIN;
          else begin
            ctl.clearIdx = 1'b1;
            nextState = S_DRD;
          end
        end else if (pollCnt == CNT_W'(POLL_LIMIT - 1)) setErr = 1'b1;
        else begin
          pollInc = 1'b1;
          gapLoad = 1'b1;
          nextState = (pollGap == '0) ? S_POLL : S_GAP;
        end
      end
      S_GAP: if (gapCnt <= GAP_W'(1)) nextState = S_POLL;
      S_DRD: if (mgmtDone) begin
        if (mgmtErr) setErr = 1'b1;
        else begin
          ctl.captureWord = 1'b1;
          if (lastWord) nextState = S_FIN;
          else ctl.incIdx = 1'b1;
        end
      end
      S_FIN: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
    if (setErr) begin
      ctl.dropData = 1'b1;
      nextState = S_FIN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; pollCnt <= '0; gapCnt <= '0; errQ <= 1'b0;
    end else begin
      state <= nextState;
      if (pollClr) pollCnt <= '0;
      else if (pollInc) pollCnt <= pollCnt + 1'b1;
      if (gapLoad) gapCnt <= pollGap;
      else if (state == S_GAP) gapCnt <= gapCnt - 1'b1;
      if (ctl.latchReq) errQ <= 1'b0;
      else if (setErr) errQ <= 1'b1;
    end
  end

  assign mgmtReq   = (ctl.kind != TX_NONE);
  assign mgmtWrite = (ctl.kind == TX_PAGE) || (ctl.kind == TX_DWR) || (ctl.kind == TX_CMD);
  assign ready     = (state == S_IDLE);
  assign done      = (state == S_FIN);
  assign error     = done && errQ;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ready && reqValid) |=> !ready);
  assert_abort_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtReq && mgmtDone && mgmtErr) |=> (!mgmtReq && done && error));
endmodule

// File: rtl/pg_seq.sv
module pg_seq
  import pg_seq_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd30,
  parameter int POLL_LIMIT = 5,
  parameter int GAP_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [7:0]       reqPage,
  input  logic [7:0]       reqReg,
  input  logic [2:0]       reqWidth,
  input  logic             reqWrite,
  input  logic [63:0]      reqWData,
  input  logic [GAP_W-1:0] pollGap,
  output logic             ready,
  output logic             done,
  output logic             error,
  output logic [63:0]      rData,
  output logic             mgmtReq,
  output logic             mgmtWrite,
  output logic [4:0]       mgmtPhy,
  output logic [4:0]       mgmtRegNum,
  output logic [15:0]      mgmtWData,
  input  logic [15:0]      mgmtRData,
  input  logic             mgmtDone,
  input  logic             mgmtErr
);
  seqCtl_t ctl;
  logic    pageHit, lastWord, latWrite;

  pg_seq_ctrl #(.POLL_LIMIT(POLL_LIMIT), .GAP_W(GAP_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .pageHit(pageHit), .lastWord(lastWord), .latWrite(latWrite),
    .mgmtDone(mgmtDone), .mgmtErr(mgmtErr), .busyBits(mgmtRData[1:0]),
    .pollGap(pollGap), .ctl(ctl), .mgmtReq(mgmtReq), .mgmtWrite(mgmtWrite),
    .ready(ready), .done(done), .error(error)
  );

  pg_seq_dp #(.PHY_ADDR(PHY_ADDR)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqPage(reqPage), .reqReg(reqReg),
    .reqWidth(reqWidth), .reqWrite(reqWrite), .reqWData(reqWData),
    .mgmtRData(mgmtRData), .pageHit(pageHit), .lastWord(lastWord),
    .latWrite(latWrite), .mgmtPhy(mgmtPhy), .mgmtRegNum(mgmtRegNum),
    .mgmtWData(mgmtWData), .rData(rData)
  );

  // checker state: width and direction of the request in flight
  logic [2:0] seenWidth;
  logic       seenWrite;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenWidth <= '0; seenWrite <= 1'b0;
    end else if (ready && reqValid) begin
      seenWidth <= reqWidth; seenWrite <= reqWrite;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtReq && !mgmtDone) |=> (mgmtReq && $stable(mgmtRegNum) && $stable(mgmtWData)));
  assert_no_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && error) |-> (rData == 64'd0));
  assert_byte_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !error && !seenWrite && seenWidth == 3'd0) |-> (rData[63:8] == 56'd0));
endmodule

// File: tb/test_pg_seq.sv
`timescale 1ns/1ps
module test_pg_seq;
  localparam logic [4:0] PHY = 5'd30;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0] reqPage = '0, reqReg = '0, pollGap = '0;
  logic [2:0] reqWidth = '0;
  logic [63:0] reqWData = '0;
  logic ready, done, error, mgmtReq, mgmtWrite;
  logic [63:0] rData;
  logic [4:0] mgmtPhy, mgmtRegNum;
  logic [15:0] mgmtWData, mgmtRData;
  logic mgmtDone, mgmtErr;

  always #2.5 clk = ~clk;

  pg_seq i_pg_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPage(reqPage), .reqReg(reqReg),
    .reqWidth(reqWidth), .reqWrite(reqWrite), .reqWData(reqWData), .pollGap(pollGap),
    .ready(ready), .done(done), .error(error), .rData(rData), .mgmtReq(mgmtReq),
    .mgmtWrite(mgmtWrite), .mgmtPhy(mgmtPhy), .mgmtRegNum(mgmtRegNum),
    .mgmtWData(mgmtWData), .mgmtRData(mgmtRData), .mgmtDone(mgmtDone), .mgmtErr(mgmtErr)
  );

  // management device model with a transaction log
  int busyCfg = 0;
  int errIdx = -1;
  logic [15:0] preData [4] = '{16'hA0A1, 16'hB0B1, 16'hC0C1, 16'hD0D1};
  int cyc = 0, busyLeft = 0, lat = 0, logN = 0;
  logic busy = 1'b0;
  logic [4:0] curReg, curPhy;
  logic curWr;
  logic [15:0] curData, cmdVal = '0;
  int curStart;
  logic [4:0] logReg [256];
  logic [4:0] logPhy [256];
  logic logWr [256];
  logic [15:0] logData [256];
  int logStart [256];
  int logDone [256];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mgmtDone <= 1'b0;
    mgmtErr <= 1'b0;
    if (!rstN) begin
      busy <= 1'b0; mgmtRData <= '0;
    end else if (busy) begin
      if (lat <= 1) begin
        busy <= 1'b0;
        mgmtDone <= 1'b1;
        logReg[logN] <= curReg; logPhy[logN] <= curPhy; logWr[logN] <= curWr;
        logData[logN] <= curData; logStart[logN] <= curStart; logDone[logN] <= cyc;
        logN <= logN + 1;
        mgmtRData <= 16'h0;
        if (logN == errIdx) mgmtErr <= 1'b1;
        else if (curWr && curReg == 5'h11) begin
          cmdVal <= curData; busyLeft <= busyCfg;
        end else if (!curWr && curReg == 5'h11) begin
          if (busyLeft > 0) begin
            mgmtRData <= cmdVal; busyLeft <= busyLeft - 1;
          end else mgmtRData <= cmdVal & 16'hFFFC;
        end else if (!curWr && curReg >= 5'h18 && curReg <= 5'h1B)
          mgmtRData <= preData[curReg - 5'h18];
      end else lat <= lat - 1;
    end else if (mgmtReq && !mgmtDone) begin
      busy <= 1'b1; lat <= 2;
      curReg <= mgmtRegNum; curPhy <= mgmtPhy; curWr <= mgmtWrite;
      curData <= mgmtWData; curStart <= cyc;
    end
  end

  int nChecks = 0, nFails = 0;
  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected log
  logic [4:0] eReg [32];
  logic eWr [32];
  logic [15:0] eData [32];
  int eN = 0;
  task automatic expPush(input logic [4:0] r, input logic w, input logic [15:0] d);
    eReg[eN] = r; eWr[eN] = w; eData[eN] = d; eN++;
  endtask
  task automatic compareLog(input string tag, input int base);
    check(logN - base == eN, {tag, " count"}, 64'(logN - base), 64'(eN));
    for (int k = 0; k < eN && k < logN - base; k++) begin
      check(logReg[base+k] == eReg[k] && logWr[base+k] == eWr[k], {tag, " reg"},
            {58'd0, logWr[base+k], logReg[base+k]}, {58'd0, eWr[k], eReg[k]});
      if (eWr[k])
        check(logData[base+k] == eData[k], {tag, " wdata"}, 64'(logData[base+k]), 64'(eData[k]));
    end
    eN = 0;
  endtask

  logic gotErr;
  logic [63:0] gotData;
  task automatic runAccess(input logic [7:0] pg, input logic [7:0] rg, input logic [2:0] w,
                           input logic wr, input logic [63:0] wd, input bit inject);
    @(negedge clk);
    while (!ready) @(negedge clk);
    reqPage = pg; reqReg = rg; reqWidth = w; reqWrite = wr; reqWData = wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (inject) begin
      @(negedge clk);
      reqPage = 8'h33; reqWrite = 1'b1; reqValid = 1'b1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(!ready, "R8 busy not ready", 64'(ready), 64'd0);
      end
      reqValid = 1'b0;
    end
    for (int k = 0; k < 400; k++) begin
      if (done) break;
      @(negedge clk);
    end
    check(done, "R8 done seen", 64'(done), 64'd1);
    gotErr = error; gotData = rData;
  endtask

  task automatic tReset;
    check(ready == 1'b1, "R8 reset ready", 64'(ready), 64'd1);
    check(done == 1'b0, "R8 reset done", 64'(done), 64'd0);
    check(mgmtReq == 1'b0, "R8 reset mgmtReq", 64'(mgmtReq), 64'd0);
  endtask

  task automatic tWrite16;
    int b = logN;
    busyCfg = 0; pollGap = 0;
    runAccess(8'h05, 8'h20, 3'd1, 1'b1, 64'h1234_5678_9ABC_BEEF, 0);
    expPush(5'h10, 1, 16'h0501); expPush(5'h18, 1, 16'hBEEF);
    expPush(5'h11, 1, 16'h2001); expPush(5'h11, 0, 16'h0);
    compareLog("R1 R2 write16", b);
    check(gotErr == 1'b0, "R2 write16 err", 64'(gotErr), 64'd0);
  endtask

  task automatic tWrite64;
    int b = logN;
    runAccess(8'h05, 8'h21, 3'd4, 1'b1, 64'h1111_2222_3333_4444, 0);
    expPush(5'h18, 1, 16'h4444); expPush(5'h19, 1, 16'h3333);
    expPush(5'h1A, 1, 16'h2222); expPush(5'h1B, 1, 16'h1111);
    expPush(5'h11, 1, 16'h2101); expPush(5'h11, 0, 16'h0);
    compareLog("R1 R2 R9 write64 page cached", b);
  endtask

  task automatic tRead48Gap;
    int b = logN;
    busyCfg = 2; pollGap = 8'd3;
    runAccess(8'h05, 8'h30, 3'd3, 1'b0, 64'h0, 0);
    expPush(5'h11, 1, 16'h3002);
    for (int k = 0; k < 3; k++) expPush(5'h11, 0, 16'h0);
    expPush(5'h18, 0, 0); expPush(5'h19, 0, 0); expPush(5'h1A, 0, 0);
    compareLog("R3 R4 read48", b);
    check(gotData == 64'h0000_C0C1_B0B1_A0A1, "R3 read48 data", gotData, 64'h0000_C0C1_B0B1_A0A1);
    check(logStart[b+1] - logDone[b] == 2, "R4 first poll no gap", 64'(logStart[b+1] - logDone[b]), 64'd2);
    check(logStart[b+2] - logDone[b+1] == 5, "R4 gap 1", 64'(logStart[b+2] - logDone[b+1]), 64'd5);
    check(logStart[b+3] - logDone[b+2] == 5, "R4 gap 2", 64'(logStart[b+3] - logDone[b+2]), 64'd5);
    pollGap = 0;
  endtask

  task automatic tRead8;
    int b = logN;
    busyCfg = 0;
    runAccess(8'h07, 8'h01, 3'd0, 1'b0, 64'h0, 0);
    expPush(5'h10, 1, 16'h0701); expPush(5'h11, 1, 16'h0102);
    expPush(5'h11, 0, 0); expPush(5'h18, 0, 0);
    compareLog("R1 R3 read8", b);
    check(gotData == 64'hA1, "R3 read8 low byte", gotData, 64'hA1);
  endtask

  task automatic tPollLimit;
    int b = logN;
    busyCfg = 4;
    runAccess(8'h07, 8'h02, 3'd2, 1'b0, 64'h0, 0);
    expPush(5'h11, 1, 16'h0202);
    for (int k = 0; k < 5; k++) expPush(5'h11, 0, 0);
    expPush(5'h18, 0, 0); expPush(5'h19, 0, 0);
    compareLog("R4 five polls ok", b);
    check(gotErr == 1'b0 && gotData == 64'hB0B1_A0A1, "R4 last poll succeeds", gotData, 64'hB0B1_A0A1);
    b = logN;
    busyCfg = 5;
    runAccess(8'h07, 8'h02, 3'd2, 1'b0, 64'h0, 0);
    expPush(5'h11, 1, 16'h0202);
    for (int k = 0; k < 5; k++) expPush(5'h11, 0, 0);
    compareLog("R5 poll exhausted", b);
    check(gotErr == 1'b1, "R5 timeout err", 64'(gotErr), 64'd1);
    check(gotData == 64'd0, "R5 no data", gotData, 64'd0);
    busyCfg = 0;
  endtask

  task automatic tAbort;
    int b = logN;
    errIdx = b + 1;
    runAccess(8'h07, 8'h40, 3'd2, 1'b1, 64'hDEAD_BEEF, 0);
    expPush(5'h18, 1, 16'hBEEF); expPush(5'h19, 1, 16'hDEAD);
    repeat (10) @(negedge clk);
    compareLog("R6 abort at data word", b);
    check(gotErr == 1'b1, "R6 abort err", 64'(gotErr), 64'd1);
    b = logN;
    errIdx = b;
    runAccess(8'h09, 8'h05, 3'd1, 1'b0, 64'h0, 0);
    expPush(5'h10, 1, 16'h0901);
    compareLog("R6 page write fails", b);
    check(gotErr == 1'b1 && gotData == 64'd0, "R6 page err data", gotData, 64'd0);
    errIdx = -1;
    b = logN;
    runAccess(8'h09, 8'h05, 3'd1, 1'b0, 64'h0, 0);
    expPush(5'h10, 1, 16'h0901); expPush(5'h11, 1, 16'h0502);
    expPush(5'h11, 0, 0); expPush(5'h18, 0, 0);
    compareLog("R1 R6 cache kept after failed page", b);
  endtask

  task automatic tIgnore;
    int b = logN;
    runAccess(8'h09, 8'h05, 3'd1, 1'b0, 64'h0, 1);
    expPush(5'h11, 1, 16'h0502); expPush(5'h11, 0, 0); expPush(5'h18, 0, 0);
    compareLog("R8 busy request ignored", b);
    check(gotData == 64'hA0A1, "R8 read16 data", gotData, 64'hA0A1);
    @(negedge clk);
    check(!done, "R8 done one cycle", 64'(done), 64'd0);
    repeat (5) @(negedge clk);
    check(rData == 64'hA0A1 && ready, "R8 rData held", rData, 64'hA0A1);
    check(logN == b + 3, "R8 no extra access", 64'(logN - b), 64'd3);
  endtask

  task automatic tWidth7;
    int b = logN;
    runAccess(8'h09, 8'h06, 3'd7, 1'b1, 64'h0004_0003_0002_0001, 0);
    expPush(5'h18, 1, 16'h1); expPush(5'h19, 1, 16'h2);
    expPush(5'h1A, 1, 16'h3); expPush(5'h1B, 1, 16'h4);
    expPush(5'h11, 1, 16'h0601); expPush(5'h11, 0, 0);
    compareLog("R9 code 7 as 64", b);
  endtask

  task automatic tPhy;
    int bad = 0;
    for (int k = 0; k < logN; k++) if (logPhy[k] != PHY) bad++;
    check(bad == 0 && logN > 0, "R7 phy address", 64'(bad), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWrite16();
    tWrite64();
    tRead48Gap();
    tRead8();
    tPollLimit();
    tAbort();
    tIgnore();
    tWidth7();
    tPhy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule